// File: doc/BRIEF.md
# Compressed Texel Block Cache with Neighbour Lookahead

This block sits between a texture address generator and a narrow external DRAM. Textures are stored compressed: each 4×4 texel block is two 8-bit palette indices and 16 selector bits. The block keeps four cells, and each cell holds one block in decoded form: two 24-bit colours and the 16 selectors. The requester presents a block coordinate and receives the decoded 64-bit entry once the block is resident. A filter stage downstream then picks each texel's colour from the selector bits.

A missing block is read as two 16-bit DRAM words. The two indices are expanded through an external colour table at the moment the block is written into its cell. Each block can go to only one cell, chosen by the low bits of its two block coordinates. After a lookup is served, the block queues the three blocks that touch the quarter of the current block where the sample point lies. It fetches those blocks while no demand fetch is waiting. A scanline-change flag stops this lookahead for the cycle in which it is raised.

Top module: `texblk_cache`

## Requirements
- R1: After reset every cell is empty: no DRAM request is raised, and the first lookup of any block is not ready in its first cycle.
- R2: A lookup of a resident block raises `lk_ready` in the same cycle. `lk_entry` is {colour a [63:40], colour b [39:16], selectors [15:0]}.
- R3: A lookup of a missing block holds `lk_ready` low until the block has been filled. The block is fetched as two word reads, at addresses {bv,bu,0} and then {bv,bu,1}. The high byte of word 0 is index a, its low byte is index b, and word 1 holds the selectors. With an idle fetcher and a one-cycle memory reply, `lk_ready` rises 5 cycles after the lookup is presented.
- R4: Block (bu,bv) lives only in cell {bv[0],bu[0]}. A fill evicts only the block that held the same cell.
- R5: A lookup that is served with `lk_line_chg` low queues three neighbours. The u step is +1 if u-quadrant bit `lk_qu` is 1 and −1 otherwise, and the v step follows `lk_qv` in the same way, with both steps wrapping modulo the coordinate range. The neighbours are (bu+du,bv), then (bu,bv+dv), then (bu+du,bv+dv), and they are fetched in that order while no demand miss is waiting.
- R6: A lookup served while `lk_line_chg` is high queues no neighbours.
- R7: A queued neighbour that is already resident, or already being fetched, causes no DRAM traffic.
- R8: A demand miss is fetched before any queued neighbour that has not yet been issued.
- R9: At most one word read is outstanding. `mem_req` and `mem_addr` stay unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_bu | input | 8 | Block u coordinate (texel u / 4) |
| lk_bv | input | 8 | Block v coordinate (texel v / 4) |
| lk_qu | input | 1 | Texel u bit 1 (quadrant) |
| lk_qv | input | 1 | Texel v bit 1 (quadrant) |
| lk_line_chg | input | 1 | Scanline change, stops lookahead this cycle |
| lk_ready | output | 1 | Requested block is resident |
| lk_entry | output | 64 | Decoded entry |
| mem_req | output | 1 | DRAM word read request |
| mem_addr | output | 17 | DRAM word address {bv,bu,word} |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| pal_idx_a | output | 8 | Colour table index a |
| pal_idx_b | output | 8 | Colour table index b |
| pal_col_a | input | 24 | Colour for index a |
| pal_col_b | input | 24 | Colour for index b |

## Verification
The assertions assume a well-behaved memory port: `mem_rvalid` pulses once per accepted request, never in the cycle of the ack itself, and replies arrive in request order. They also assume the colour table answers combinationally. The bench memory model acks at once or after a programmed delay, and registers its reply one cycle after the ack. Its palette is a pure function of the index, so every fill sees a stable colour.

// File: rtl/texblk_pkg.sv
package texblk_pkg;
  localparam int NCELL = 4;
  localparam int SEL_W = 16;
  localparam int NNB   = 3;

  typedef enum logic [2:0] {
    F_IDLE,
    F_REQ0,
    F_WAIT0,
    F_REQ1,
    F_WAIT1
  } fetch_st_e;

  function automatic logic [1:0] cell_of(input logic bu0, input logic bv0);
    return {bv0, bu0};
  endfunction
endpackage

// File: rtl/tbc_tags.sv
module tbc_tags
  import texblk_pkg::*;
#(
  parameter int BC_W  = 8,
  parameter int ENT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BC_W-1:0]  rd_bu,
  input  logic [BC_W-1:0]  rd_bv,
  input  logic [BC_W-1:0]  pr_bu,
  input  logic [BC_W-1:0]  pr_bv,
  input  logic             wr_en,
  input  logic [BC_W-1:0]  wr_bu,
  input  logic [BC_W-1:0]  wr_bv,
  input  logic [ENT_W-1:0] wr_ent,
  output logic             rd_hit,
  output logic [ENT_W-1:0] rd_ent,
  output logic             pr_hit
);
  localparam int TAG_W = 2 * (BC_W - 1);

  logic             valid_q [NCELL];
  logic [TAG_W-1:0] tag_q   [NCELL];
  logic [ENT_W-1:0] ent_q   [NCELL];

  logic [1:0]       wr_cell, rd_cell, pr_cell;
  logic [TAG_W-1:0] wr_tag, rd_tag, pr_tag;

  always_comb begin
    wr_cell = cell_of(wr_bu[0], wr_bv[0]);
    rd_cell = cell_of(rd_bu[0], rd_bv[0]);
    pr_cell = cell_of(pr_bu[0], pr_bv[0]);
    wr_tag  = {wr_bv[BC_W-1:1], wr_bu[BC_W-1:1]};
    rd_tag  = {rd_bv[BC_W-1:1], rd_bu[BC_W-1:1]};
    pr_tag  = {pr_bv[BC_W-1:1], pr_bu[BC_W-1:1]};
    rd_hit  = valid_q[rd_cell] && (tag_q[rd_cell] == rd_tag);
    pr_hit  = valid_q[pr_cell] && (tag_q[pr_cell] == pr_tag);
    rd_ent  = ent_q[rd_cell];
  end

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    logic we_c;
    assign we_c = wr_en && (wr_cell == 2'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    valid_q[c] <= 1'b0;
      else if (we_c) valid_q[c] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (we_c) begin
        tag_q[c] <= wr_tag;
        ent_q[c] <= wr_ent;
      end
    end
  end

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_cell)] && tag_q[$past(wr_cell)] == $past(wr_tag)); // R3
endmodule

// File: rtl/tbc_fetch.sv
module tbc_fetch
  import texblk_pkg::*;
#(
  parameter int BC_W  = 8,
  parameter int MEM_W = 16,
  parameter int COL_W = 24,
  localparam int IDX_W = MEM_W / 2,
  localparam int ADR_W = 2 * BC_W + 1,
  localparam int ENT_W = 2 * COL_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BC_W-1:0]  start_bu,
  input  logic [BC_W-1:0]  start_bv,
  output logic             busy,
  output logic [BC_W-1:0]  cur_bu,
  output logic [BC_W-1:0]  cur_bv,
  output logic             mem_req,
  output logic [ADR_W-1:0] mem_addr,
  input  logic             mem_ack,
  input  logic             mem_rvalid,
  input  logic [MEM_W-1:0] mem_rdata,
  output logic [IDX_W-1:0] pal_idx_a,
  output logic [IDX_W-1:0] pal_idx_b,
  input  logic [COL_W-1:0] pal_col_a,
  input  logic [COL_W-1:0] pal_col_b,
  output logic             fill_en,
  output logic [ENT_W-1:0] fill_ent
);
  fetch_st_e        st_q, st_d;
  logic [BC_W-1:0]  bu_q, bv_q;
  logic [MEM_W-1:0] idx_q;
  logic             blk_en, idx_en;

  always_comb begin
    st_d   = st_q;
    blk_en = 1'b0;
    idx_en = 1'b0;
    unique case (st_q)
      F_IDLE:  if (start) begin st_d = F_REQ0; blk_en = 1'b1; end
      F_REQ0:  if (mem_ack) st_d = F_WAIT0;
      F_WAIT0: if (mem_rvalid) begin st_d = F_REQ1; idx_en = 1'b1; end
      F_REQ1:  if (mem_ack) st_d = F_WAIT1;
      F_WAIT1: if (mem_rvalid) st_d = F_IDLE;
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= F_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (blk_en) begin
      bu_q <= start_bu;
      bv_q <= start_bv;
    end
    if (idx_en) idx_q <= mem_rdata;
  end

  always_comb begin
    busy      = (st_q != F_IDLE);
    cur_bu    = bu_q;
    cur_bv    = bv_q;
    mem_req   = (st_q == F_REQ0) || (st_q == F_REQ1);
    mem_addr  = {bv_q, bu_q, (st_q == F_REQ1)};
    pal_idx_a = idx_q[MEM_W-1:IDX_W];
    pal_idx_b = idx_q[IDX_W-1:0];
    fill_en   = (st_q == F_WAIT1) && mem_rvalid;
    fill_ent  = {pal_col_a, pal_col_b, mem_rdata[SEL_W-1:0]};
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R9
  AST_RVALID_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (st_q == F_WAIT0) || (st_q == F_WAIT1)); // R9
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R9
endmodule

// File: rtl/tbc_ahead.sv
module tbc_ahead
  import texblk_pkg::*;
#(
  parameter int BC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [BC_W-1:0] cap_bu,
  input  logic [BC_W-1:0] cap_bv,
  input  logic            cap_qu,
  input  logic            cap_qv,
  input  logic            consume,
  output logic            pf_valid,
  output logic [BC_W-1:0] pf_bu,
  output logic [BC_W-1:0] pf_bv
);
  logic [NNB-1:0]  pend_q, pend_d;
  logic [BC_W-1:0] nb_bu_q [NNB];
  logic [BC_W-1:0] nb_bv_q [NNB];
  logic [BC_W-1:0] du, dv;
  logic [1:0]      sel;

  assign du = cap_qu ? BC_W'(1) : {BC_W{1'b1}};
  assign dv = cap_qv ? BC_W'(1) : {BC_W{1'b1}};

  for (genvar k = 0; k < NNB; k++) begin : g_nb
    localparam bit STEP_U = (k != 1);
    localparam bit STEP_V = (k != 0);
    always_ff @(posedge clk) begin
      if (capture) begin
        nb_bu_q[k] <= STEP_U ? cap_bu + du : cap_bu;
        nb_bv_q[k] <= STEP_V ? cap_bv + dv : cap_bv;
      end
    end
  end

  always_comb begin
    sel = 2'd0;
    for (int k = NNB - 1; k >= 0; k--) begin
      if (pend_q[k]) sel = 2'(k);
    end
    pf_valid = |pend_q;
    pf_bu    = nb_bu_q[sel];
    pf_bv    = nb_bv_q[sel];
    pend_d   = pend_q;
    if (capture)      pend_d = '1;
    else if (consume) pend_d[sel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  AST_CONSUME_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> pf_valid); // R7
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !capture && pf_valid |=> $countones(pend_q) <= $countones($past(pend_q))); // R5
endmodule

// File: rtl/texblk_cache.sv
module texblk_cache
  import texblk_pkg::*;
#(
  parameter int BC_W  = 8,
  parameter int MEM_W = 16,
  parameter int COL_W = 24,
  localparam int IDX_W = MEM_W / 2,
  localparam int ADR_W = 2 * BC_W + 1,
  localparam int ENT_W = 2 * COL_W + SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [BC_W-1:0]  lk_bu,
  input  logic [BC_W-1:0]  lk_bv,
  input  logic             lk_qu,
  input  logic             lk_qv,
  input  logic             lk_line_chg,
  output logic             lk_ready,
  output logic [ENT_W-1:0] lk_entry,
  output logic             mem_req,
  output logic [ADR_W-1:0] mem_addr,
  input  logic             mem_ack,
  input  logic             mem_rvalid,
  input  logic [MEM_W-1:0] mem_rdata,
  output logic [IDX_W-1:0] pal_idx_a,
  output logic [IDX_W-1:0] pal_idx_b,
  input  logic [COL_W-1:0] pal_col_a,
  input  logic [COL_W-1:0] pal_col_b
);
  logic             rst_s0, rst_q;
  logic             rd_hit, pr_hit;
  logic             busy, fill_en, start;
  logic [BC_W-1:0]  cur_bu, cur_bv, pf_bu, pf_bv, st_bu, st_bv;
  logic [ENT_W-1:0] fill_ent;
  logic             pf_valid, capture, consume, pf_issue, pf_skip, dem_miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_q  <= rst_s0;
    end
  end

  always_comb begin
    dem_miss = lk_valid && !rd_hit;
    capture  = lk_valid && rd_hit && !lk_line_chg;
    pf_skip  = pf_valid && !lk_line_chg &&
               (pr_hit || (busy && pf_bu == cur_bu && pf_bv == cur_bv));
    pf_issue = pf_valid && !lk_line_chg && !busy && !dem_miss && !pr_hit;
    consume  = pf_skip || pf_issue;
    start    = !busy && (dem_miss || pf_issue);
    st_bu    = dem_miss ? lk_bu : pf_bu;
    st_bv    = dem_miss ? lk_bv : pf_bv;
    lk_ready = rd_hit;
  end

  tbc_tags #(.BC_W(BC_W), .ENT_W(ENT_W)) u_tags (
    .clk(clk), .rst_n(rst_q),
    .rd_bu(lk_bu), .rd_bv(lk_bv),
    .pr_bu(pf_bu), .pr_bv(pf_bv),
    .wr_en(fill_en), .wr_bu(cur_bu), .wr_bv(cur_bv), .wr_ent(fill_ent),
    .rd_hit(rd_hit), .rd_ent(lk_entry), .pr_hit(pr_hit)
  );

  tbc_fetch #(.BC_W(BC_W), .MEM_W(MEM_W), .COL_W(COL_W)) u_fetch (
    .clk(clk), .rst_n(rst_q),
    .start(start), .start_bu(st_bu), .start_bv(st_bv),
    .busy(busy), .cur_bu(cur_bu), .cur_bv(cur_bv),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pal_idx_a(pal_idx_a), .pal_idx_b(pal_idx_b),
    .pal_col_a(pal_col_a), .pal_col_b(pal_col_b),
    .fill_en(fill_en), .fill_ent(fill_ent)
  );

  tbc_ahead #(.BC_W(BC_W)) u_ahead (
    .clk(clk), .rst_n(rst_q),
    .capture(capture), .cap_bu(lk_bu), .cap_bv(lk_bv),
    .cap_qu(lk_qu), .cap_qv(lk_qv), .consume(consume),
    .pf_valid(pf_valid), .pf_bu(pf_bu), .pf_bv(pf_bv)
  );

  AST_MISS_STARTS: assert property (@(posedge clk) disable iff (!rst_q)
    lk_valid && !lk_ready && !busy |=> busy); // R3
  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_q)
    lk_valid && !lk_ready && !busy |=> cur_bu == $past(lk_bu) && cur_bv == $past(lk_bv)); // R8
  AST_LINECHG_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_q)
    lk_line_chg && !pf_valid |=> !pf_valid); // R6
endmodule

// File: tb/texblk_cache_test.sv
module texblk_cache_test;
  localparam int BC_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_qu = 1'b0, lk_qv = 1'b0, lk_line_chg = 1'b0;
  logic [7:0]  lk_bu = '0, lk_bv = '0;
  logic        lk_ready;
  logic [63:0] lk_entry;
  logic        mem_req, mem_ack, mem_rvalid = 1'b0;
  logic [16:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  pal_idx_a, pal_idx_b;
  logic [23:0] pal_col_a, pal_col_b;
  logic        ack_en = 1'b1;

  int total = 0, bad = 0, nlog = 0;
  bit done = 0;
  logic [16:0] lg [256];

  always #10 clk = ~clk;

  texblk_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_bu(lk_bu), .lk_bv(lk_bv),
    .lk_qu(lk_qu), .lk_qv(lk_qv), .lk_line_chg(lk_line_chg),
    .lk_ready(lk_ready), .lk_entry(lk_entry),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pal_idx_a(pal_idx_a), .pal_idx_b(pal_idx_b),
    .pal_col_a(pal_col_a), .pal_col_b(pal_col_b)
  );

  function automatic logic [15:0] memw(input logic [16:0] a);
    int x;
    x = int'(a) * 40503 + 12345;
    return x[15:0];
  endfunction

  function automatic logic [23:0] pal(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  function automatic logic [16:0] wadr(input int bu, input int bv, input bit w);
    return {bv[7:0], bu[7:0], w};
  endfunction

  function automatic logic [63:0] exp_ent(input int bu, input int bv);
    logic [15:0] w0, w1;
    w0 = memw(wadr(bu, bv, 1'b0));
    w1 = memw(wadr(bu, bv, 1'b1));
    return {pal(w0[15:8]), pal(w0[7:0]), w1};
  endfunction

  assign mem_ack   = mem_req && ack_en;
  assign pal_col_a = pal(pal_idx_a);
  assign pal_col_b = pal(pal_idx_b);

  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_ack;
    mem_rdata  <= memw(mem_addr);
    if (mem_req && mem_ack) begin
      lg[nlog % 256] <= mem_addr;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 1'b0; lk_line_chg = 1'b0; ack_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive(input int u, input int v, input bit lc);
    lk_bu = u[9:2]; lk_bv = v[9:2]; lk_qu = u[1]; lk_qv = v[1];
    lk_line_chg = lc; lk_valid = 1'b1;
  endtask

  task automatic lookup(input int u, input int v, input bit lc,
                        output logic [63:0] ent, output int waits);
    @(negedge clk);
    drive(u, v, lc);
    waits = 0;
    #2;
    while (!lk_ready && waits < 200) begin
      @(negedge clk); #2; waits++;
    end
    ent = lk_entry;
    @(negedge clk);
    lk_valid = 1'b0; lk_line_chg = 1'b0;
  endtask

  // u[20:11], v[10:1], miss[0]
  localparam logic [20:0] VEC [10] = '{
    {10'd0,    10'd0,    1'b1},
    {10'd4,    10'd0,    1'b1},
    {10'd1,    10'd2,    1'b0},
    {10'd8,    10'd0,    1'b1},
    {10'd5,    10'd3,    1'b0},
    {10'd0,    10'd0,    1'b1},
    {10'd4,    10'd4,    1'b1},
    {10'd1023, 10'd1023, 1'b1},
    {10'd7,    10'd6,    1'b1},
    {10'd0,    10'd3,    1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] e;
    int w, mark;

    // R1: reset state
    do_reset();
    chk(mem_req == 1'b0, "R1 no request after reset", 64'(mem_req), 0);
    @(negedge clk); drive(0, 0, 1'b1); #2;
    chk(lk_ready == 1'b0, "R1 first lookup not ready", 64'(lk_ready), 0);
    @(negedge clk); lk_valid = 1'b0; lk_line_chg = 1'b0;

    // R2 R3 R4: vector table, lookahead off
    do_reset();
    for (int i = 0; i < 10; i++) begin
      int u, v;
      u = int'(VEC[i][20:11]); v = int'(VEC[i][10:1]);
      lookup(u, v, 1'b1, e, w);
      chk(e == exp_ent(u / 4, v / 4), "R2 entry content", e, exp_ent(u / 4, v / 4));
      if (VEC[i][0]) chk(w == 5, "R3 miss latency", 64'(w), 5);
      else           chk(w == 0, "R4 hit same cycle", 64'(w), 0);
    end

    // R5: lookahead neighbours and order
    do_reset();
    mark = nlog;
    lookup(5 * 4 + 2, 7 * 4 + 1, 1'b0, e, w);
    repeat (40) @(negedge clk);
    chk(nlog - mark == 8, "R5 fetch count", 64'(nlog - mark), 8);
    chk(lg[(mark + 0) % 256] == wadr(5, 7, 0), "R3 word0 address", 64'(lg[(mark + 0) % 256]), 64'(wadr(5, 7, 0)));
    chk(lg[(mark + 1) % 256] == wadr(5, 7, 1), "R3 word1 address", 64'(lg[(mark + 1) % 256]), 64'(wadr(5, 7, 1)));
    chk(lg[(mark + 2) % 256] == wadr(6, 7, 0), "R5 u neighbour", 64'(lg[(mark + 2) % 256]), 64'(wadr(6, 7, 0)));
    chk(lg[(mark + 4) % 256] == wadr(5, 6, 0), "R5 v neighbour", 64'(lg[(mark + 4) % 256]), 64'(wadr(5, 6, 0)));
    chk(lg[(mark + 6) % 256] == wadr(6, 6, 0), "R5 diagonal", 64'(lg[(mark + 6) % 256]), 64'(wadr(6, 6, 0)));
    lookup(6 * 4, 6 * 4, 1'b1, e, w);
    chk(w == 0 && e == exp_ent(6, 6), "R5 prefetched block resident", e, exp_ent(6, 6));

    // R7: same block, same quadrant, neighbours resident
    mark = nlog;
    lookup(5 * 4 + 2, 7 * 4 + 1, 1'b0, e, w);
    repeat (20) @(negedge clk);
    chk(nlog == mark, "R7 no refetch of resident neighbours", 64'(nlog - mark), 0);

    // R5: wrap-around at coordinate edges
    do_reset();
    mark = nlog;
    lookup(1, 1023, 1'b0, e, w);
    repeat (40) @(negedge clk);
    chk(lg[(mark + 2) % 256] == wadr(255, 255, 0), "R5 wrap u", 64'(lg[(mark + 2) % 256]), 64'(wadr(255, 255, 0)));
    chk(lg[(mark + 4) % 256] == wadr(0, 0, 0), "R5 wrap v", 64'(lg[(mark + 4) % 256]), 64'(wadr(0, 0, 0)));
    chk(lg[(mark + 6) % 256] == wadr(255, 0, 0), "R5 wrap diagonal", 64'(lg[(mark + 6) % 256]), 64'(wadr(255, 0, 0)));

    // R6: scanline change suppresses lookahead
    do_reset();
    mark = nlog;
    lookup(42, 40, 1'b1, e, w);
    repeat (30) @(negedge clk);
    chk(nlog - mark == 2, "R6 no lookahead on line change", 64'(nlog - mark), 2);

    // R8: demand miss before queued neighbours
    mark = nlog;
    @(negedge clk); drive(42, 40, 1'b0);
    @(negedge clk); drive(120, 120, 1'b0);
    #2; w = 0;
    while (!lk_ready && w < 200) begin @(negedge clk); #2; w++; end
    @(negedge clk); lk_valid = 1'b0; lk_line_chg = 1'b0;
    chk(lg[mark % 256] == wadr(30, 30, 0), "R8 demand first", 64'(lg[mark % 256]), 64'(wadr(30, 30, 0)));
    repeat (40) @(negedge clk);

    // R9: request held until ack
    do_reset();
    ack_en = 1'b0;
    @(negedge clk); drive(12, 12, 1'b1);
    repeat (4) begin
      @(negedge clk); #2;
      chk(mem_req == 1'b1 && mem_addr == wadr(3, 3, 0), "R9 request held",
          64'({mem_req, mem_addr}), 64'({1'b1, wadr(3, 3, 0)}));
    end
    ack_en = 1'b1;
    w = 0;
    while (!lk_ready && w < 200) begin @(negedge clk); #2; w++; end
    chk(lk_entry == exp_ent(3, 3), "R9 entry after delayed ack", lk_entry, exp_ent(3, 3));
    @(negedge clk); lk_valid = 1'b0; lk_line_chg = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule